// File: doc/BRIEF.md
# USB Endpoint Control Register Bank

This block keeps the control and status byte of every endpoint of a USB device controller. The CPU reaches all of them through two addresses. One holds an endpoint selector. The other is a window onto the control byte of whichever endpoint the selector names. Software uses each byte to enable the endpoint, choose its transfer type and direction, and enable its NAK interrupt.

The protocol engine reports two kinds of event: a NAK handshake sent in answer to a host IN or a host OUT, and a DATA0 or DATA1 packet received. Each event carries an endpoint index. NAK events set sticky flags that only software can clear. Received data PIDs drive a read-only toggle status bit. One registered interrupt line combines the enabled NAK flags of all endpoints.

Top module: `usb_ep_ctrl_bank`

## Requirements
- R1: The window byte has this layout: bit 7 endpoint enable, bit 6 NAK interrupt enable, bit 5 NAK-after-OUT flag, bit 4 NAK-after-IN flag, bit 3 toggle status, bit 2 direction, bits 1:0 type.
- R2: After reset every endpoint byte reads 8'h80, so each endpoint is enabled with all other fields clear, and the selector reads 0.
- R3: Address 0 holds the selector, which reads back on bits 2:0 with zeros above. Window accesses at address 1 read or write only the endpoint the selector names.
- R4: A NAK-after-OUT event sets bit 5 of the addressed endpoint on the next clock. A NAK-after-IN event sets bit 4 of that endpoint on the next clock.
- R5: A window write of 0 to bit 5 or bit 4 clears that flag. A write of 1 leaves it unchanged. A hardware set in the same cycle as a software clear leaves the flag at 1.
- R6: A received DATA1 sets bit 3 of the addressed endpoint and a received DATA0 clears it. Software writes to bit 3 have no effect.
- R7: The irq output is high one clock after any endpoint has bit 6 set together with bit 5 or bit 4. An endpoint with bit 6 clear never raises irq.
- R8: When the selector is 4 or more, the window reads 8'h00 and window writes change no endpoint.
- R9: Software can write bits 7, 6 and 2 and the type field, and they read back as written. The type codes are 00 control, 01 isochronous, 10 bulk and 11 interrupt, and the direction bit is stored for any type.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 1 | 0 selects the endpoint selector, 1 selects the window |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data of the addressed register |
| nak_out_ev | input | 1 | A NAK was sent in answer to a host OUT |
| nak_in_ev | input | 1 | A NAK was sent in answer to a host IN |
| dat_ev | input | 1 | A data packet was received |
| dat_one | input | 1 | The received packet was DATA1 (0 means DATA0) |
| ev_ep | input | 3 | Endpoint index that the event strobes refer to |
| irq | output | 1 | Registered NAK interrupt request |

## Verification
The bench drives a hardware NAK set and a software clear onto the same flag in the same cycle. A design that lets the clear win loses a NAK report. It writes all ones to the window to show that a write of 1 cannot set a flag and that software cannot change the toggle bit. A design that treats those bits as ordinary storage fails here. It checks irq on the exact clock after a flag changes, and it raises a flag on an endpoint whose interrupt is disabled. A design that drives irq combinationally, or ignores the enable, shows up there. With the selector out of range, the window must read zero and a write of all ones must not reach any endpoint. A design that truncates the selector would alias the write onto endpoint 1.

// File: rtl/usb_epc_pkg.sv
// Shared field positions, type codes and the per-endpoint register image
// for the endpoint control bank. The layout is fixed at 8 bits.
package usb_epc_pkg;

    // Transfer type codes held in bits 1:0
    typedef enum logic [1:0] {
        EPT_CTRL = 2'b00,
        EPT_ISO  = 2'b01,
        EPT_BULK = 2'b10,
        EPT_INTR = 2'b11
    } ep_type_e;

    // Register image, MSB first, in the bit order software sees
    typedef struct packed {
        logic     en;
        logic     nak_ie;
        logic     nak_out;
        logic     nak_in;
        logic     tog;
        logic     dir_in;
        ep_type_e kind;
    } ep_ctrl_t;

    localparam int REG_W  = 8;
    localparam int B_NOUT = 5;
    localparam int B_NIN  = 4;

    localparam ep_ctrl_t EP_RST = '{
        en: 1'b1, nak_ie: 1'b0, nak_out: 1'b0, nak_in: 1'b0,
        tog: 1'b0, dir_in: 1'b0, kind: EPT_CTRL
    };

endpackage

// File: rtl/usb_epc_slot.sv
// One endpoint's control byte.
// Assumes: wr_hit is already qualified by the selector and address; the
// event inputs are already decoded to this endpoint. Hardware sets of the
// NAK flags take priority over software clears.
module usb_epc_slot
    import usb_epc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_hit,
    input  ep_ctrl_t wdata,
    input  logic     nout_set,
    input  logic     nin_set,
    input  logic     dat_hit,
    input  logic     dat_one,
    output ep_ctrl_t q
);

    ep_ctrl_t q_r;

    // Update the register from software writes and engine events
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_r <= EP_RST;
        end else begin
            if (wr_hit) begin
                q_r.en     <= wdata.en;
                q_r.nak_ie <= wdata.nak_ie;
                q_r.dir_in <= wdata.dir_in;
                q_r.kind   <= wdata.kind;
            end
            if (nout_set)
                q_r.nak_out <= 1'b1;
            else if (wr_hit && !wdata.nak_out)
                q_r.nak_out <= 1'b0;
            if (nin_set)
                q_r.nak_in <= 1'b1;
            else if (wr_hit && !wdata.nak_in)
                q_r.nak_in <= 1'b0;
            if (dat_hit)
                q_r.tog <= dat_one;
        end
    end

    assign q = q_r;

endmodule

// File: rtl/usb_epc_window.sv
// Selector register and windowed access decode.
// Assumes: address 0 is the selector and address 1 is the window; the
// selector is SEL_W bits wide (SEL_W < 8). Selector values at or above
// NUM_EP match no slot, so the window reads zero and writes go nowhere.
module usb_epc_window
    import usb_epc_pkg::*;
#(
    parameter int NUM_EP = 4,
    parameter int SEL_W  = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_addr,
    input  logic                   bus_wr,
    input  logic [REG_W-1:0]       bus_wdata,
    input  ep_ctrl_t [NUM_EP-1:0]  slot_q,
    output logic [SEL_W-1:0]       sel,
    output logic [NUM_EP-1:0]      wr_hit,
    output logic [REG_W-1:0]       bus_rdata
);

    logic [SEL_W-1:0] sel_r;
    logic [REG_W-1:0] win_rd;

    // Hold the endpoint selector
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_r <= '0;
        else if (bus_wr && !bus_addr)
            sel_r <= bus_wdata[SEL_W-1:0];
    end

    // Decode window writes to the selected slot
    always_comb begin
        for (int i = 0; i < NUM_EP; i++)
            wr_hit[i] = bus_wr && bus_addr && (sel_r == SEL_W'(i));
    end

    // Multiplex the selected slot onto the window
    always_comb begin
        win_rd = '0;
        for (int i = 0; i < NUM_EP; i++)
            if (sel_r == SEL_W'(i))
                win_rd = slot_q[i];
    end

    // Drive read data for the addressed register
    assign bus_rdata = bus_addr ? win_rd : {{(REG_W-SEL_W){1'b0}}, sel_r};
    assign sel = sel_r;

endmodule

// File: rtl/usb_epc_irq.sv
// Combines the enabled NAK flags of all endpoints into one interrupt line
// with one register stage.
// Assumes: the slot images are the current register outputs.
module usb_epc_irq
    import usb_epc_pkg::*;
#(
    parameter int NUM_EP = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  ep_ctrl_t [NUM_EP-1:0] slot_q,
    output logic                  irq
);

    logic [NUM_EP-1:0] src;
    logic              irq_r;

    // Per-endpoint interrupt source, gated by its enable
    always_comb begin
        for (int i = 0; i < NUM_EP; i++)
            src[i] = slot_q[i].nak_ie && (slot_q[i].nak_out || slot_q[i].nak_in);
    end

    // Register the combined request
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_r <= 1'b0;
        else
            irq_r <= |src;
    end

    assign irq = irq_r;

endmodule

// File: rtl/usb_ep_ctrl_bank.sv
// Endpoint control register bank: NUM_EP control bytes reached through an
// endpoint selector and a single window address, with NAK event flags,
// toggle tracking and a registered interrupt.
// Assumes: the event strobes are single-cycle pulses from the protocol
// engine; an ev_ep value at or above NUM_EP addresses no endpoint.
module usb_ep_ctrl_bank
    import usb_epc_pkg::*;
#(
    parameter int NUM_EP = 4,
    parameter int SEL_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_addr,
    input  logic             bus_wr,
    input  logic [7:0]       bus_wdata,
    output logic [7:0]       bus_rdata,
    input  logic             nak_out_ev,
    input  logic             nak_in_ev,
    input  logic             dat_ev,
    input  logic             dat_one,
    input  logic [SEL_W-1:0] ev_ep,
    output logic             irq
);

    ep_ctrl_t [NUM_EP-1:0] regs;
    logic     [NUM_EP-1:0] wr_hit;
    logic     [SEL_W-1:0]  sel;

    usb_epc_window #(.NUM_EP(NUM_EP), .SEL_W(SEL_W)) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .slot_q    (regs),
        .sel       (sel),
        .wr_hit    (wr_hit),
        .bus_rdata (bus_rdata)
    );

    for (genvar i = 0; i < NUM_EP; i++) begin : g_slot
        logic ev_hit;
        assign ev_hit = (ev_ep == SEL_W'(i));
        usb_epc_slot u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_hit   (wr_hit[i]),
            .wdata    (ep_ctrl_t'(bus_wdata)),
            .nout_set (nak_out_ev && ev_hit),
            .nin_set  (nak_in_ev && ev_hit),
            .dat_hit  (dat_ev && ev_hit),
            .dat_one  (dat_one),
            .q        (regs[i])
        );
    end

    usb_epc_irq #(.NUM_EP(NUM_EP)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .slot_q (regs),
        .irq    (irq)
    );

endmodule

// File: rtl/usb_ep_ctrl_bank_chk.sv
// Property checker for the endpoint control bank, bound to every instance.
module usb_ep_ctrl_bank_chk
    import usb_epc_pkg::*;
#(
    parameter int NUM_EP = 4,
    parameter int SEL_W  = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_addr,
    input logic                  bus_wr,
    input logic [7:0]            bus_wdata,
    input logic [7:0]            bus_rdata,
    input logic                  nak_out_ev,
    input logic                  nak_in_ev,
    input logic                  dat_ev,
    input logic [SEL_W-1:0]      ev_ep,
    input logic [SEL_W-1:0]      sel,
    input ep_ctrl_t [NUM_EP-1:0] regs,
    input logic                  irq
);

    logic any_src;
    always_comb begin
        any_src = 1'b0;
        for (int i = 0; i < NUM_EP; i++)
            if (regs[i].nak_ie && (regs[i].nak_out || regs[i].nak_in))
                any_src = 1'b1;
    end

    p_oob_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr && int'(sel) >= NUM_EP) |-> bus_rdata == 8'h00);

    p_irq_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !any_src |=> !irq);

    for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
        logic clr_out, clr_in;
        assign clr_out = bus_wr && bus_addr && sel == SEL_W'(i) && !bus_wdata[B_NOUT];
        assign clr_in  = bus_wr && bus_addr && sel == SEL_W'(i) && !bus_wdata[B_NIN];

        p_set_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (nak_out_ev && ev_ep == SEL_W'(i)) |=> regs[i].nak_out);

        p_set_in_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (nak_in_ev && ev_ep == SEL_W'(i)) |=> regs[i].nak_in);

        p_hold_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (regs[i].nak_out && !clr_out) |=> regs[i].nak_out);

        p_hold_in_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (regs[i].nak_in && !clr_in) |=> regs[i].nak_in);

        p_tog_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !(dat_ev && ev_ep == SEL_W'(i)) |=> $stable(regs[i].tog));

        p_irq_raise_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (regs[i].nak_ie && (regs[i].nak_out || regs[i].nak_in)) |=> irq);
    end

endmodule

bind usb_ep_ctrl_bank usb_ep_ctrl_bank_chk #(.NUM_EP(NUM_EP), .SEL_W(SEL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .nak_out_ev (nak_out_ev),
    .nak_in_ev  (nak_in_ev),
    .dat_ev     (dat_ev),
    .ev_ep      (ev_ep),
    .sel        (sel),
    .regs       (regs),
    .irq        (irq)
);

// File: tb/tb_usb_ep_ctrl_bank.sv
`timescale 1ns/100ps
module tb_usb_ep_ctrl_bank;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_addr = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       nak_out_ev = 1'b0;
    logic       nak_in_ev = 1'b0;
    logic       dat_ev = 1'b0;
    logic       dat_one = 1'b0;
    logic [2:0] ev_ep = 3'd0;
    logic       irq;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    usb_ep_ctrl_bank dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .nak_out_ev(nak_out_ev),
        .nak_in_ev(nak_in_ev), .dat_ev(dat_ev), .dat_one(dat_one),
        .ev_ep(ev_ep), .irq(irq)
    );

    // Vector fields: {is_write, addr, data, expected read}
    localparam int NV = 22;
    localparam logic [17:0] VEC [NV] = '{
        {1'b0, 1'b0, 8'h00, 8'h00},  // R2 selector resets to 0
        {1'b0, 1'b1, 8'h00, 8'h80},  // R2 ep0 reset value
        {1'b1, 1'b1, 8'hFF, 8'h00},  // write all ones to ep0
        {1'b0, 1'b1, 8'h00, 8'hC7},  // R1 R5 R6 R9 flags and toggle stay 0
        {1'b1, 1'b0, 8'h02, 8'h00},  // select ep2
        {1'b0, 1'b0, 8'h00, 8'h02},  // R3 selector readback
        {1'b0, 1'b1, 8'h00, 8'h80},  // R3 ep2 untouched
        {1'b1, 1'b1, 8'h06, 8'h00},  // ep2: disabled, IN, bulk
        {1'b0, 1'b1, 8'h00, 8'h06},  // R9 bulk IN readback
        {1'b1, 1'b0, 8'h00, 8'h00},  // select ep0
        {1'b0, 1'b1, 8'h00, 8'hC7},  // R3 ep0 kept its value
        {1'b1, 1'b0, 8'h05, 8'h00},  // select out of range
        {1'b0, 1'b0, 8'h00, 8'h05},  // R3 selector holds 5
        {1'b0, 1'b1, 8'h00, 8'h00},  // R8 reads zero
        {1'b1, 1'b1, 8'hFF, 8'h00},  // R8 write ignored
        {1'b0, 1'b1, 8'h00, 8'h00},  // R8 still zero
        {1'b1, 1'b0, 8'h03, 8'h00},  // select ep3
        {1'b0, 1'b1, 8'h00, 8'h80},  // R2 R8 ep3 untouched
        {1'b1, 1'b0, 8'h01, 8'h00},  // select ep1
        {1'b0, 1'b1, 8'h00, 8'h80},  // R8 no alias of sel 5 onto ep1
        {1'b1, 1'b1, 8'h01, 8'h00},  // ep1: disabled, OUT, isochronous
        {1'b0, 1'b1, 8'h00, 8'h01}   // R9 isochronous readback
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input string tag, input logic a, input logic [7:0] exp);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic pulse(input logic no, input logic ni, input logic de,
                         input logic d1, input logic [2:0] ep);
        @(negedge clk);
        nak_out_ev = no; nak_in_ev = ni; dat_ev = de; dat_one = d1; ev_ep = ep;
        @(negedge clk);
        nak_out_ev = 1'b0; nak_in_ev = 1'b0; dat_ev = 1'b0; dat_one = 1'b0;
    endtask

    task automatic report;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL watchdog actual=timeout expected=completion");
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R7 irq low after reset", {7'd0, irq}, 8'h00);

        // Table walk: R1 R2 R3 R8 R9
        for (int k = 0; k < NV; k++) begin
            if (VEC[k][17])
                bus_write(VEC[k][16], VEC[k][15:8]);
            else
                bus_read($sformatf("R1/R2/R3/R8/R9 table vector %0d", k),
                         VEC[k][16], VEC[k][7:0]);
        end

        // ep0 = C7 with its NAK interrupt enabled
        bus_write(1'b0, 8'h00);
        pulse(1'b1, 1'b0, 1'b0, 1'b0, 3'd0);
        bus_read("R4 NAK-after-OUT set", 1'b1, 8'hE7);
        chk("R7 irq not yet high", {7'd0, irq}, 8'h00);
        @(negedge clk); #1;
        chk("R7 irq one clock later", {7'd0, irq}, 8'h01);

        bus_write(1'b1, 8'hFF);
        bus_read("R5 write 1 keeps flag, R6 toggle write ignored", 1'b1, 8'hE7);
        bus_write(1'b1, 8'hC7);
        bus_read("R5 write 0 clears flag", 1'b1, 8'hC7);
        #1;
        chk("R7 irq still high one clock after clear", {7'd0, irq}, 8'h01);
        @(negedge clk); #1;
        chk("R7 irq drops after clear", {7'd0, irq}, 8'h00);

        // Set and clear of NAK-after-IN in the same cycle
        @(negedge clk);
        bus_addr = 1'b1; bus_wr = 1'b1; bus_wdata = 8'hC7;
        nak_in_ev = 1'b1; ev_ep = 3'd0;
        @(negedge clk);
        bus_wr = 1'b0; nak_in_ev = 1'b0;
        bus_read("R5 hardware set wins over clear", 1'b1, 8'hD7);
        bus_write(1'b1, 8'hC7);
        bus_read("R5 NAK-after-IN cleared", 1'b1, 8'hC7);

        // Masked endpoint: ep2 has its NAK interrupt disabled
        repeat (2) @(negedge clk);
        pulse(1'b0, 1'b1, 1'b0, 1'b0, 3'd2);
        bus_write(1'b0, 8'h02);
        bus_read("R4 NAK-after-IN on ep2", 1'b1, 8'h16);
        @(negedge clk); #1;
        chk("R7 disabled endpoint keeps irq low", {7'd0, irq}, 8'h00);
        bus_write(1'b1, 8'h06);
        bus_read("R5 ep2 flag cleared", 1'b1, 8'h06);

        // Toggle tracking on ep0
        bus_write(1'b0, 8'h00);
        pulse(1'b0, 1'b0, 1'b1, 1'b1, 3'd0);
        bus_read("R6 DATA1 sets toggle", 1'b1, 8'hCF);
        bus_write(1'b1, 8'hC7);
        bus_read("R6 toggle ignores software", 1'b1, 8'hCF);
        pulse(1'b0, 1'b0, 1'b1, 1'b1, 3'd1);
        bus_read("R6 DATA1 on ep1 leaves ep0", 1'b1, 8'hCF);
        pulse(1'b0, 1'b0, 1'b1, 1'b0, 3'd0);
        bus_read("R6 DATA0 clears toggle", 1'b1, 8'hC7);
        bus_write(1'b0, 8'h01);
        bus_read("R6 ep1 toggle set", 1'b1, 8'h09);

        done = 1'b1;
        report();
    end

endmodule